// File: doc/BRIEF.md
# Event Link Supercycle Monitor

This block watches the decoded event codes arriving on a timing event link and checks, cycle by cycle over a 600-cycle supercycle, that the events which actually occurred match the schedule that was planned. It is an independent hardware check on the software that builds the schedule. Any difference latches a fault that stays set until the host clears it.

A host loads a small map that assigns up to 16 event codes to bit positions. It also loads one expected 16-bit word per machine cycle into an expected table. While running, the block ORs the bit of every mapped event into an accumulator. The cycle-start marker closes the running cycle. On that edge the accumulator is compared with the expected word for the current cycle index, and the accumulator is also stored in an observed table. The host can read the observed table back to confirm what the pattern generators really produced.

A separate supercycle-start input resynchronises the cycle index to zero. On the first mismatch the block records the failing index and the bitwise difference. A second sticky flag reports an event that occurred twice within one cycle.

Top module: `event_schedule_monitor`

## Requirements
- R1: Writing `map_we` with `map_slot`, `map_code` and `map_en`=1 makes every later `evt_valid` carrying that code set bit `map_slot` of the running cycle's observed word.
- R2: An event whose code matches no enabled slot changes neither the observed word nor any flag.
- R3: A `cyc_start` pulse closes the running cycle. An event presented on the same clock as that pulse is counted in the cycle that opens, not the one that closes.
- R4: After arming, the first cycle closed has index 0. Each further `cyc_start` advances `cyc_idx` by one, and the index wraps from 599 to 0.
- R5: A `sc_start` pulse sets `cyc_idx` to 0 and discards the partial pattern without a comparison. When it coincides with `cyc_start`, the closing cycle is still compared at its current index and the next index is 0.
- R6: When a closed cycle's observed word differs from the expected word written via `exp_we`/`exp_addr`/`exp_wdata` at that index, `fault` is 1 from the next clock on.
- R7: On the first mismatch since reset or clear, `first_idx` takes the failing index and `first_diff` takes observed XOR expected. Both hold through later mismatches.
- R8: `fault_clr` returns `fault`, `dup_flag`, `first_idx` and `first_diff` to 0. A mismatch closing on the same clock wins and is captured anew.
- R9: Presenting `obs_rd_addr` gives the stored observed word for that index on `obs_rd_data` one clock later.
- R10: A second occurrence of the same mapped event within one cycle sets the sticky `dup_flag`.
- R11: After reset all outputs are 0 and the block is idle. Until the first `cyc_start` or `sc_start` arms it, no comparison takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_valid | input | 1 | Decoded event present |
| evt_code | input | 8 | Decoded event code |
| cyc_start | input | 1 | Cycle-start marker, closes a cycle |
| sc_start | input | 1 | Supercycle-start marker, index resync |
| map_we | input | 1 | Map slot write strobe |
| map_slot | input | 4 | Slot (bit position) to write |
| map_code | input | 8 | Event code for the slot |
| map_en | input | 1 | Slot enable |
| exp_we | input | 1 | Expected table write strobe |
| exp_addr | input | 10 | Expected table index |
| exp_wdata | input | 16 | Expected word |
| obs_rd_addr | input | 10 | Observed table read index |
| obs_rd_data | output | 16 | Observed word, one clock after address |
| fault_clr | input | 1 | Clear fault, duplicate flag and capture |
| cyc_idx | output | 10 | Index of the running cycle |
| fault | output | 1 | Sticky mismatch fault |
| dup_flag | output | 1 | Sticky duplicate-event flag |
| first_idx | output | 10 | Index of the first failing cycle |
| first_diff | output | 16 | Observed XOR expected at first failure |

## Verification
Two activities can land on the same clock: an event arriving and the cycle-start pulse that closes the cycle. The bench presents a mapped event together with `cyc_start`. It then judges the outcome by the captured difference for the closing cycle and by the readback of the following cycle's observed word. The host clear is also issued on the very clock a mismatching cycle closes, and the fault must stay set with the new capture. The supercycle resync is pulsed together with `cyc_start` to show that the comparison uses the old index.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   typedef enum logic {
      MON_IDLE = 1'b0,
      MON_RUN  = 1'b1
   } mon_state_e;

   function automatic int unsigned idx_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/evmon_decode.sv
module evmon_decode #(
   parameter int unsigned N_SLOTS = 16,
   parameter int unsigned CODE_W  = 8,
   localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_we,
   input  logic [SLOT_W-1:0]  map_slot,
   input  logic [CODE_W-1:0]  map_code,
   input  logic               map_en,
   input  logic               evt_valid,
   input  logic [CODE_W-1:0]  evt_code,
   output logic [N_SLOTS-1:0] hit
);
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      logic [CODE_W-1:0] code_q;
      logic              en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= '0;
            en_q   <= 1'b0;
         end else if (map_we && map_slot == SLOT_W'(s)) begin
            code_q <= map_code;
            en_q   <= map_en;
         end
      end
      assign hit[s] = evt_valid && en_q && (evt_code == code_q);
   end
endmodule

// File: rtl/evmon_accum.sv
module evmon_accum #(
   parameter int unsigned N_SLOTS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               armed,
   input  logic               close,
   input  logic [N_SLOTS-1:0] hit,
   output logic [N_SLOTS-1:0] acc,
   output logic               dup_seen
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (close) acc <= hit;
      else            acc <= acc | hit;
   end

   assign dup_seen = armed && !close && |(acc & hit);

   // R3
   acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !close |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/evmon_mem.sv
module evmon_mem #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned DEPTH  = 600,
   parameter bit          REG_RD = 1'b1,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [WIDTH-1:0] store [DEPTH];
   logic [WIDTH-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (we && waddr <= LAST) store[waddr] <= wdata;
   end

   assign rd_word = (raddr <= LAST) ? store[raddr] : '0;

   if (REG_RD) begin : g_sync_rd
      always_ff @(posedge clk) rdata <= rd_word;
   end else begin : g_async_rd
      assign rdata = rd_word;
   end
endmodule

// File: rtl/event_schedule_monitor.sv
module event_schedule_monitor #(
   parameter int unsigned N_SLOTS = 16,
   parameter int unsigned CYCLES  = 600,
   parameter int unsigned CODE_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       evt_valid,
   input  logic [CODE_W-1:0]          evt_code,
   input  logic                       cyc_start,
   input  logic                       sc_start,
   input  logic                       map_we,
   input  logic [$clog2(N_SLOTS)-1:0] map_slot,
   input  logic [CODE_W-1:0]          map_code,
   input  logic                       map_en,
   input  logic                       exp_we,
   input  logic [$clog2(CYCLES)-1:0]  exp_addr,
   input  logic [N_SLOTS-1:0]         exp_wdata,
   input  logic [$clog2(CYCLES)-1:0]  obs_rd_addr,
   output logic [N_SLOTS-1:0]         obs_rd_data,
   input  logic                       fault_clr,
   output logic [$clog2(CYCLES)-1:0]  cyc_idx,
   output logic                       fault,
   output logic                       dup_flag,
   output logic [$clog2(CYCLES)-1:0]  first_idx,
   output logic [N_SLOTS-1:0]         first_diff
);
   import evmon_pkg::*;

   localparam int unsigned IDX_W = $clog2(CYCLES);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("CYCLES must be at least 2");
   end
   if (N_SLOTS < 2 || N_SLOTS > 64) begin : g_bad_slots
      $error("N_SLOTS must lie in 2..64");
   end
   if ((2 ** CODE_W) < N_SLOTS) begin : g_bad_code
      $error("CODE_W too narrow for N_SLOTS distinct codes");
   end

   mon_state_e        state;
   logic [N_SLOTS-1:0] hit, acc, exp_word;
   logic              close, do_cmp, mism, dup_seen, armed;

   assign armed  = (state == MON_RUN);
   assign close  = cyc_start || sc_start;
   assign do_cmp = armed && cyc_start;
   assign mism   = do_cmp && (acc != exp_word);

   evmon_decode #(.N_SLOTS(N_SLOTS), .CODE_W(CODE_W)) u_decode (
      .clk(clk), .rst_n(rst_n),
      .map_we(map_we), .map_slot(map_slot), .map_code(map_code), .map_en(map_en),
      .evt_valid(evt_valid), .evt_code(evt_code), .hit(hit)
   );

   evmon_accum #(.N_SLOTS(N_SLOTS)) u_accum (
      .clk(clk), .rst_n(rst_n), .armed(armed), .close(close),
      .hit(hit), .acc(acc), .dup_seen(dup_seen)
   );

   evmon_mem #(.WIDTH(N_SLOTS), .DEPTH(CYCLES), .REG_RD(1'b0)) u_exp_tab (
      .clk(clk), .we(exp_we), .waddr(exp_addr), .wdata(exp_wdata),
      .raddr(cyc_idx), .rdata(exp_word)
   );

   evmon_mem #(.WIDTH(N_SLOTS), .DEPTH(CYCLES), .REG_RD(1'b1)) u_obs_tab (
      .clk(clk), .we(do_cmp), .waddr(cyc_idx), .wdata(acc),
      .raddr(obs_rd_addr), .rdata(obs_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= MON_IDLE;
         cyc_idx <= '0;
      end else if (!armed) begin
         if (close) begin
            state   <= MON_RUN;
            cyc_idx <= '0;
         end
      end else if (sc_start) begin
         cyc_idx <= '0;
      end else if (cyc_start) begin
         cyc_idx <= (cyc_idx == IDX_LAST) ? '0 : cyc_idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault      <= 1'b0;
         dup_flag   <= 1'b0;
         first_idx  <= '0;
         first_diff <= '0;
      end else begin
         if (mism) fault <= 1'b1;
         else if (fault_clr) fault <= 1'b0;

         if (dup_seen) dup_flag <= 1'b1;
         else if (fault_clr) dup_flag <= 1'b0;

         if (mism && (!fault || fault_clr)) begin
            first_idx  <= cyc_idx;
            first_diff <= acc ^ exp_word;
         end else if (fault_clr) begin
            first_idx  <= '0;
            first_diff <= '0;
         end
      end
   end

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_idx <= IDX_LAST);
   // R4
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && cyc_start && !sc_start && cyc_idx == IDX_LAST |=> cyc_idx == '0);
   // R5
   resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sc_start |=> cyc_idx == '0);
   // R6
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !fault_clr |=> fault);
   // R7
   first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !fault_clr |=> $stable(first_idx) && $stable(first_diff));
   // R10
   dup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dup_flag && !fault_clr |=> dup_flag);
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !fault && cyc_idx == '0);
endmodule

// File: tb/event_schedule_monitor_test.sv
module event_schedule_monitor_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCYC = 600;

   logic        clk = 0, rst_n = 0;
   logic        evt_valid = 0, cyc_start = 0, sc_start = 0;
   logic [7:0]  evt_code = 0, map_code = 0;
   logic        map_we = 0, map_en = 0, exp_we = 0, fault_clr = 0;
   logic [3:0]  map_slot = 0;
   logic [9:0]  exp_addr = 0, obs_rd_addr = 0;
   logic [15:0] exp_wdata = 0;
   logic [15:0] obs_rd_data, first_diff;
   logic [9:0]  cyc_idx, first_idx;
   logic        fault, dup_flag;

   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   event_schedule_monitor uut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .cyc_start(cyc_start), .sc_start(sc_start), .map_we(map_we), .map_slot(map_slot),
      .map_code(map_code), .map_en(map_en), .exp_we(exp_we), .exp_addr(exp_addr),
      .exp_wdata(exp_wdata), .obs_rd_addr(obs_rd_addr), .obs_rd_data(obs_rd_data),
      .fault_clr(fault_clr), .cyc_idx(cyc_idx), .fault(fault), .dup_flag(dup_flag),
      .first_idx(first_idx), .first_diff(first_diff)
   );

   function automatic logic [15:0] pat(input int i);
      return 16'(i * 40503) ^ 16'(i << 5) ^ 16'h1234;
   endfunction

   function automatic logic [7:0] code_of(input int b);
      return 8'(8'h10 + b * 3);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock of stimulus, driven at a falling edge, ends at the next falling edge
   task automatic step(input bit ev, input logic [7:0] code, input bit cs,
                       input bit ss, input bit clr);
      evt_valid = ev; evt_code = code; cyc_start = cs; sc_start = ss; fault_clr = clr;
      @(negedge clk);
      evt_valid = 0; cyc_start = 0; sc_start = 0; fault_clr = 0;
   endtask

   task automatic send_pat(input logic [15:0] p);
      for (int b = 0; b < 16; b++) if (p[b]) step(1, code_of(b), 0, 0, 0);
   endtask

   task automatic read_obs(input int a, output logic [15:0] d);
      obs_rd_addr = 10'(a);
      @(negedge clk);
      d = obs_rd_data;
   endtask

   int lowb;
   logic [15:0] rd, m;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 fault", fault, 0);
      chk("R11 dup", dup_flag, 0);
      chk("R11 idx", cyc_idx, 0);
      chk("R11 first_idx", first_idx, 0);
      chk("R11 first_diff", first_diff, 0);

      for (int s = 0; s < 16; s++) begin
         map_we = 1; map_slot = 4'(s); map_code = code_of(s); map_en = 1;
         @(negedge clk);
      end
      map_we = 0;
      for (int i = 0; i < NCYC; i++) begin
         exp_we = 1; exp_addr = 10'(i); exp_wdata = pat(i);
         @(negedge clk);
      end
      exp_we = 0;

      // R11 idle: events before arming cause no comparison
      send_pat(16'h00F0);
      chk("R11 idle fault", fault, 0);
      step(0, 0, 1, 0, 0);   // arms, opens cycle 0
      chk("R11 armed idx", cyc_idx, 0);
      chk("R11 armed fault", fault, 0);

      // full supercycle: R1, R2, R4, R6
      for (int i = 0; i < NCYC; i++) begin
         send_pat(pat(i));
         step(1, 8'h05, 0, 0, 0);   // R2 unmapped code
         step(1, 8'hF0, 0, 0, 0);   // R2 unmapped code
         step(0, 0, 1, 0, 0);
         chk("R4 idx", cyc_idx, (i + 1) % NCYC);
         chk("R6 no fault", fault, 0);
      end
      chk("R2 dup", dup_flag, 0);
      // R9 readback of observed supercycle (also confirms R1, R2)
      for (int i = 0; i < NCYC; i++) begin
         read_obs(i, rd);
         chk("R9 readback", rd, pat(i));
      end

      // R6/R7 mismatch at cycle 0
      send_pat(pat(0) ^ 16'h0001);
      step(0, 0, 1, 0, 0);
      chk("R6 fault", fault, 1);
      chk("R7 first_idx", first_idx, 0);
      chk("R7 first_diff", first_diff, 16'h0001);
      send_pat(pat(1) ^ 16'h8000);
      step(0, 0, 1, 0, 0);
      chk("R7 hold idx", first_idx, 0);
      chk("R7 hold diff", first_diff, 16'h0001);
      step(0, 0, 0, 0, 1);
      chk("R8 clr fault", fault, 0);
      chk("R8 clr idx", first_idx, 0);
      chk("R8 clr diff", first_diff, 0);

      // R3 event on the closing clock belongs to the next cycle
      lowb = 0;
      while (!pat(2)[lowb]) lowb++;
      m = 16'(1 << lowb);
      send_pat(pat(2) & ~m);
      step(1, code_of(lowb), 1, 0, 0);
      chk("R3 fault", fault, 1);
      chk("R3 first_idx", first_idx, 2);
      chk("R3 first_diff", first_diff, m);
      send_pat(pat(3) & ~m);
      step(0, 0, 1, 0, 0);
      read_obs(2, rd);
      chk("R3 obs closing", rd, pat(2) & ~m);
      read_obs(3, rd);
      chk("R3 obs opening", rd, pat(3) | m);
      step(0, 0, 0, 0, 1);

      // R10 duplicate within a cycle (cycle 4, pattern otherwise right)
      lowb = 0;
      while (!pat(4)[lowb]) lowb++;
      send_pat(pat(4));
      chk("R10 no dup yet", dup_flag, 0);
      step(1, code_of(lowb), 0, 0, 0);
      chk("R10 dup", dup_flag, 1);
      step(0, 0, 1, 0, 0);
      chk("R10 fault", fault, 0);

      // R8 clear coinciding with a mismatching close (cycle 5)
      send_pat(pat(5) ^ 16'h0010);
      step(0, 0, 1, 0, 1);
      chk("R8 set wins", fault, 1);
      chk("R8 new idx", first_idx, 5);
      chk("R8 new diff", first_diff, 16'h0010);
      chk("R8 dup cleared", dup_flag, 0);
      step(0, 0, 0, 0, 1);
      chk("R8 clear", fault, 0);

      // R5 resync discards partial cycle 6
      send_pat(16'h0F0F);
      step(0, 0, 0, 1, 0);
      chk("R5 idx", cyc_idx, 0);
      chk("R5 no cmp", fault, 0);
      send_pat(pat(0));
      step(0, 0, 1, 0, 0);
      chk("R5 discard", fault, 0);
      chk("R5 idx1", cyc_idx, 1);
      send_pat(pat(1));
      step(0, 0, 1, 1, 0);
      chk("R5 coincident cmp", fault, 0);
      chk("R5 coincident idx", cyc_idx, 0);
      read_obs(1, rd);
      chk("R5 coincident obs", rd, pat(1));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule